// File: doc/BRIEF.md
# Shared Exclusive Reservation Monitor

This block arbitrates exclusive load/store pairs issued by several cores against coherent shared memory. For each core it holds one reservation: a valid flag and the tag of the granule that the core last loaded exclusively. When a core issues an exclusive store, the block decides in that same cycle whether the store may commit. The store commits only if the core's reservation still covers the store's granule. Any write that reaches a granule removes every other reservation on that granule. Such a write is a committed exclusive store or a plain store from any core.

Each core drives a 2-bit operation code and an address every cycle. The operation and the commit/fail answer are plain per-cycle control signals. There is no handshake, because the block never stalls. Cache line transfer, snoop data paths and memory storage lie outside the block. Only the reservation state and the pass/fail decisions are modelled.

Top module: `gexm_top`

## Requirements
- R1: After reset every reservation is open. An exclusive store issued before any exclusive load fails and does not commit.
- R2: The per-core operation code is 00 idle, 01 exclusive load, 10 exclusive store, 11 plain store. An exclusive load sets that core's reservation to the granule of its address. A later exclusive store by that core to the same granule asserts commit and not fail, combinationally in the cycle the store is presented.
- R3: The granule tag is the address with its low GRAN_LG bits dropped. An exclusive store to another byte of the reserved granule passes. An exclusive store to a different granule fails.
- R4: Every exclusive store returns the issuing core's reservation to open, whether it passes or fails. A second exclusive store without a new exclusive load fails.
- R5: When two cores reserve the same granule, the first exclusive store to commit passes. It also opens the other core's reservation, so that core's later exclusive store fails with no commit.
- R6: Reservations on different granules are independent. Both cores' exclusive stores pass in either order.
- R7: A core whose exclusive store failed succeeds when it repeats the exclusive load and then the exclusive store with no intervening write to the granule.
- R8: A plain store from any core, the reserving core included, opens all reservations on its granule. Reservations on other granules are unaffected.
- R9: When several cores present exclusive stores to one granule in the same cycle, only the lowest-indexed core with a valid matching reservation passes and the others fail. Exclusive stores to different granules in the same cycle all pass.
- R10: Commit and fail are never both high. Either is high only for a core presenting an exclusive store, and exactly one of them is high for such a core.
- R11: Within a cycle, exclusive-store decisions come before that cycle's writes, and writes come before that cycle's exclusive loads. A reservation set in the same cycle as another core's write to the granule survives. A plain store in the same cycle does not fail an exclusive store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_op_i | input | 2*N_CORES | Per-core operation code, core k at bits [2k+1:2k] |
| core_addr_i | input | N_CORES*ADDR_W | Per-core byte address, core k at bits [k*ADDR_W +: ADDR_W] |
| xs_commit_o | output | N_CORES | Exclusive store of core k passes and may write |
| xs_fail_o | output | N_CORES | Exclusive store of core k fails and must not write |

## Verification
The hardest situations to reach are same-cycle collisions: several cores storing exclusively to one granule at once, or an exclusive load landing in the same cycle as a peer's write to that granule. Directed steps drive all cores together to hit each of these orderings. After that, a long sweep issues random operations from three cores over only four granules, so collisions and reservation races occur in most cycles. A cycle-level model derived from the ordering rules predicts every core's commit and fail.

// File: rtl/gexm_pkg.sv
package gexm_pkg;
  typedef enum logic [1:0] {
    XOP_IDLE  = 2'b00,
    XOP_LDEX  = 2'b01,
    XOP_STEX  = 2'b10,
    XOP_STORE = 2'b11
  } xop_e;
endpackage

// File: rtl/gexm_resv_entry.sv
module gexm_resv_entry #(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_own_i,
  input  logic             snoop_hit_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (set_i) begin
      // loads are ordered after this cycle's writes (R11)
      valid_o <= 1'b1;
      tag_o   <= set_tag_i;
    end else if (clr_own_i || snoop_hit_i) begin
      valid_o <= 1'b0;
    end
  end

  p_load_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (valid_o && tag_o == $past(set_tag_i)));
endmodule

// File: rtl/gexm_contend.sv
module gexm_contend #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CORES-1:0]         cand_i,
  input  logic [N_CORES*TAG_W-1:0]   tag_i,
  output logic [N_CORES-1:0]         win_o
);
  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      win_o[i] = cand_i[i];
      for (int j = 0; j < i; j++) begin
        if (cand_i[j] && tag_i[j*TAG_W +: TAG_W] == tag_i[i*TAG_W +: TAG_W])
          win_o[i] = 1'b0;
      end
    end
  end

  for (genvar a = 0; a < N_CORES; a++) begin : g_pa
    for (genvar b = a + 1; b < N_CORES; b++) begin : g_pb
      p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_o[a] && win_o[b] && tag_i[a*TAG_W +: TAG_W] == tag_i[b*TAG_W +: TAG_W]));
    end
  end
endmodule

// File: rtl/gexm_snoop.sv
module gexm_snoop #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 12
) (
  input  logic [N_CORES-1:0]         wr_en_i,
  input  logic [N_CORES*TAG_W-1:0]   wr_tag_i,
  input  logic [N_CORES-1:0]         resv_valid_i,
  input  logic [N_CORES*TAG_W-1:0]   resv_tag_i,
  output logic [N_CORES-1:0]         hit_o
);
  always_comb begin
    for (int e = 0; e < N_CORES; e++) begin
      hit_o[e] = 1'b0;
      for (int k = 0; k < N_CORES; k++) begin
        if (resv_valid_i[e] && wr_en_i[k] &&
            wr_tag_i[k*TAG_W +: TAG_W] == resv_tag_i[e*TAG_W +: TAG_W])
          hit_o[e] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gexm_top.sv
module gexm_top
  import gexm_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 16,
  parameter int GRAN_LG = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*N_CORES-1:0]        core_op_i,
  input  logic [N_CORES*ADDR_W-1:0]   core_addr_i,
  output logic [N_CORES-1:0]          xs_commit_o,
  output logic [N_CORES-1:0]          xs_fail_o
);
  localparam int TAG_W = ADDR_W - GRAN_LG;

  logic [N_CORES-1:0]       is_ld, is_stex, is_st;
  logic [N_CORES-1:0]       resv_valid, cand, win, wr_en, hit;
  logic [N_CORES*TAG_W-1:0] req_tag, resv_tag;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    xop_e op;
    assign op         = xop_e'(core_op_i[2*g +: 2]);
    assign is_ld[g]   = (op == XOP_LDEX);
    assign is_stex[g] = (op == XOP_STEX);
    assign is_st[g]   = (op == XOP_STORE);
    assign req_tag[g*TAG_W +: TAG_W] = core_addr_i[g*ADDR_W + GRAN_LG +: TAG_W];
    assign cand[g] = is_stex[g] && resv_valid[g] &&
                     (resv_tag[g*TAG_W +: TAG_W] == req_tag[g*TAG_W +: TAG_W]);

    gexm_resv_entry #(.TAG_W(TAG_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (is_ld[g]),
      .set_tag_i  (req_tag[g*TAG_W +: TAG_W]),
      .clr_own_i  (is_stex[g]),
      .snoop_hit_i(hit[g]),
      .valid_o    (resv_valid[g]),
      .tag_o      (resv_tag[g*TAG_W +: TAG_W])
    );
  end

  gexm_contend #(.N_CORES(N_CORES), .TAG_W(TAG_W)) u_contend (
    .clk   (clk),
    .rst_n (rst_n),
    .cand_i(cand),
    .tag_i (req_tag),
    .win_o (win)
  );

  // writes reaching memory this cycle: committed exclusives and plain stores
  assign wr_en = win | is_st;

  gexm_snoop #(.N_CORES(N_CORES), .TAG_W(TAG_W)) u_snoop (
    .wr_en_i     (wr_en),
    .wr_tag_i    (req_tag),
    .resv_valid_i(resv_valid),
    .resv_tag_i  (resv_tag),
    .hit_o       (hit)
  );

  assign xs_commit_o = win;
  assign xs_fail_o   = is_stex & ~win;

  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(xs_commit_o[c] && xs_fail_o[c]));
    p_resp_on_stex_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xs_commit_o[c] || xs_fail_o[c]) == (core_op_i[2*c +: 2] == 2'b10));
    p_stex_opens_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_op_i[2*c +: 2] == 2'b10) |=> !resv_valid[c]);
    for (genvar d = 0; d < N_CORES; d++) begin : g_peer
      if (c != d) begin : g_ne
        p_commit_opens_peer_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (xs_commit_o[c] && core_op_i[2*d +: 2] != 2'b01 &&
           resv_tag[d*TAG_W +: TAG_W] == core_addr_i[c*ADDR_W + GRAN_LG +: TAG_W])
          |=> !resv_valid[d]);
      end
    end
  end
endmodule

// File: tb/tb_gexm_top.sv
module tb_gexm_top;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int GL = 2;
  localparam int TW = AW - GL;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*N-1:0]  op = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N-1:0]    commit, fail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_v[N];
  logic [TW-1:0] m_t[N];

  gexm_top #(.N_CORES(N), .ADDR_W(AW), .GRAN_LG(GL)) dut (
    .clk(clk), .rst_n(rst_n), .core_op_i(op), .core_addr_i(addr),
    .xs_commit_o(commit), .xs_fail_o(fail)
  );

  always #10 clk = ~clk;

  task automatic set_op(input int c, input logic [1:0] o, input logic [AW-1:0] a);
    op[2*c +: 2]     = o;
    addr[c*AW +: AW] = a;
  endtask

  task automatic check(input string rq, input int c, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s core %0d commit/fail actual %b expected %b", rq, c, act, exp);
    end
  endtask

  // Apply current inputs for one cycle: check outputs, then advance the model.
  task automatic step(input string rq);
    bit pass[N];
    logic [TW-1:0] tg[N];
    #5;
    for (int i = 0; i < N; i++) tg[i] = addr[i*AW + GL +: TW];
    for (int i = 0; i < N; i++) begin
      pass[i] = (op[2*i +: 2] == 2'b10) && m_v[i] && m_t[i] == tg[i];
      for (int j = 0; j < i; j++)
        if (op[2*j +: 2] == 2'b10 && m_v[j] && m_t[j] == tg[j] && tg[j] == tg[i])
          pass[i] = 0;
    end
    for (int i = 0; i < N; i++)
      check(rq, i, {commit[i], fail[i]},
            {pass[i], (op[2*i +: 2] == 2'b10) && !pass[i]});
    for (int e = 0; e < N; e++) begin
      if (op[2*e +: 2] == 2'b01) begin
        m_v[e] = 1; m_t[e] = tg[e];
      end else if (op[2*e +: 2] == 2'b10) begin
        m_v[e] = 0;
      end else begin
        for (int k = 0; k < N; k++)
          if ((pass[k] || op[2*k +: 2] == 2'b11) && tg[k] == m_t[e]) m_v[e] = 0;
      end
    end
    @(negedge clk);
    op = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, then exclusive store with no reservation
    step("R1");
    set_op(0, 2'b10, 6'h10); step("R1");
    // R2
    set_op(0, 2'b01, 6'h10); step("R2");
    set_op(0, 2'b10, 6'h10); step("R2");
    // R3: same granule other byte, then different granule
    set_op(0, 2'b01, 6'h10); step("R3");
    set_op(0, 2'b10, 6'h13); step("R3");
    set_op(0, 2'b01, 6'h10); step("R3");
    set_op(0, 2'b10, 6'h14); step("R3");
    // R4: second store without reload
    set_op(1, 2'b01, 6'h20); step("R4");
    set_op(1, 2'b10, 6'h20); step("R4");
    set_op(1, 2'b10, 6'h20); step("R4");
    // R5 then R7
    set_op(0, 2'b01, 6'h20); set_op(1, 2'b01, 6'h21); step("R5");
    set_op(0, 2'b10, 6'h20); step("R5");
    set_op(1, 2'b10, 6'h22); step("R5");
    set_op(1, 2'b01, 6'h20); step("R7");
    set_op(1, 2'b10, 6'h20); step("R7");
    // R6: both orders
    set_op(0, 2'b01, 6'h04); set_op(1, 2'b01, 6'h08); step("R6");
    set_op(1, 2'b10, 6'h08); step("R6");
    set_op(0, 2'b10, 6'h04); step("R6");
    set_op(0, 2'b01, 6'h04); set_op(1, 2'b01, 6'h08); step("R6");
    set_op(0, 2'b10, 6'h04); step("R6");
    set_op(1, 2'b10, 6'h08); step("R6");
    // R8: peer plain store, then self plain store
    set_op(0, 2'b01, 6'h08); set_op(1, 2'b01, 6'h0C); step("R8");
    set_op(2, 2'b11, 6'h09); step("R8");
    set_op(0, 2'b10, 6'h08); set_op(1, 2'b10, 6'h0C); step("R8");
    set_op(0, 2'b01, 6'h08); step("R8");
    set_op(0, 2'b11, 6'h08); step("R8");
    set_op(0, 2'b10, 6'h08); step("R8");
    // R9: three-way same granule, mixed granules
    set_op(0, 2'b01, 6'h30); set_op(1, 2'b01, 6'h30); set_op(2, 2'b01, 6'h31); step("R9");
    set_op(0, 2'b10, 6'h30); set_op(1, 2'b10, 6'h30); set_op(2, 2'b10, 6'h30); step("R9");
    set_op(0, 2'b01, 6'h30); set_op(1, 2'b01, 6'h34); set_op(2, 2'b01, 6'h30); step("R9");
    set_op(0, 2'b10, 6'h30); set_op(1, 2'b10, 6'h34); set_op(2, 2'b10, 6'h30); step("R9");
    set_op(1, 2'b01, 6'h34); set_op(2, 2'b01, 6'h30); step("R9");
    set_op(1, 2'b10, 6'h34); set_op(2, 2'b10, 6'h30); step("R9");
    // R11: load racing a write; plain store racing an exclusive store
    set_op(0, 2'b01, 6'h3C); set_op(1, 2'b11, 6'h3C); step("R11");
    set_op(0, 2'b10, 6'h3C); step("R11");
    set_op(0, 2'b01, 6'h2C); step("R11");
    set_op(0, 2'b10, 6'h2C); set_op(1, 2'b11, 6'h2D); step("R11");
    // R10: random sweep over four granules
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < N; c++)
        set_op(c, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 15)));
      step("R10");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule